// File: doc/BRIEF.md
# Hybrid conditional-sum lookahead adder

This block adds two unsigned WIDTH-bit operands and a carry-in, giving a WIDTH-bit sum and a carry-out. It is purely combinational and is assembled from explicit gates and 2:1 multiplexers rather than a behavioural `+`. The operands are cut into 4-bit groups. Inside each group a conditional-sum network builds two candidate results, one for a group carry-in of 0 and one for 1. The carry that picks between them comes from a radix-4 generate/propagate lookahead tree, not from a chain of selects.

A build-time parameter picks one of two group forms. The sum-and-carry form multiplexes candidate sums and candidate carries at every merge level. The carry-only form multiplexes only per-bit candidate carries, then forms each sum bit once at the end as propagate XOR the selected carry. WIDTH must be a power of 4 of at least 16; the default of 256 gives four lookahead levels.

Top module: `hcla_adder`

## Requirements
- R1: In sum-and-carry mode (MODE = SEL_SUM_CARRY), {cout_o, sum_o} equals a_i + b_i + cin_i, computed at WIDTH+1 bits, for every input combination.
- R2: In carry-only mode (MODE = SEL_CARRY_ONLY), {cout_o, sum_o} equals a_i + b_i + cin_i, computed at WIDTH+1 bits, for every input combination.
- R3: An all-ones operand plus one, whether the one comes from cin_i = 1 with b_i = 0 or from b_i = 1 with cin_i = 0, gives sum_o = 0 and cout_o = 1.
- R4: With a_i = 0 and b_i = 0, sum_o equals cin_i in bit 0 and zero elsewhere, and cout_o = 0.
- R5: When a_i = ~b_i, so that every bit propagates, every bit of sum_o equals ~cin_i and cout_o equals cin_i.
- R6: The alternating patterns sum correctly. Here P01 has bit 0 set and then every second bit, and P10 = ~P01. P01 + P01 gives sum P10 with cout 0. P10 + P10 gives sum P01 - 1 with cout 1. P01 + P10 + cin_i gives all ones and cout 0 when cin_i = 0, and zero and cout 1 when cin_i = 1.
- R7: The lookahead carry into group 0 (bits 3:0) equals cin_i. Each group's own selected carry-out equals the lookahead carry into the next group up. The top group's carry-out equals cout_o. This means a carry made in bits 4j+3..4j appears in bit 4j+4 of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | first operand, unsigned |
| b_i | input | WIDTH | second operand, unsigned |
| cin_i | input | 1 | carry into bit 0 |
| sum_o | output | WIDTH | low WIDTH bits of the sum |
| cout_o | output | 1 | carry out of bit WIDTH-1 |

## Verification
Two paths can carry the same fact in one evaluation. A group's own conditional-sum network produces its carry-out, and the lookahead tree produces the carry into the next group, and both must agree. The walk sets a carry at each group boundary in turn, with 0xF in one group plus 1. Fully propagating operands (a = ~b) and alternating patterns make the tree's carry and the group's internal selection decide the same bits together. The result is judged at the ports against an arithmetic sum, and group by group by the bound checker. A sweep over every 16-bit first operand with a derived second operand and carry-in runs in both modes.

// File: rtl/hcla_pkg.sv
package hcla_pkg;
  typedef enum logic {
    SEL_SUM_CARRY  = 1'b0,
    SEL_CARRY_ONLY = 1'b1
  } sel_mode_e;

  localparam int unsigned GRP_W = 4;  // bits per leaf group and tree radix
endpackage

// File: rtl/hcla_mux2.sv
module hcla_mux2 (
  input  logic sel_i,
  input  logic d0_i,
  input  logic d1_i,
  output logic y_o
);
  assign y_o = (sel_i & d1_i) | (~sel_i & d0_i);
endmodule

// File: rtl/hcla_gp4.sv
// Radix-4 group generate/propagate.
module hcla_gp4 (
  input  logic [3:0] g_i,
  input  logic [3:0] p_i,
  output logic       g_o,
  output logic       p_o
);
  assign g_o = g_i[3]
             | (p_i[3] & g_i[2])
             | (p_i[3] & p_i[2] & g_i[1])
             | (p_i[3] & p_i[2] & p_i[1] & g_i[0]);
  assign p_o = p_i[3] & p_i[2] & p_i[1] & p_i[0];
endmodule

// File: rtl/hcla_carry4.sv
// Two-level carries into the four children of one tree node.
module hcla_carry4 (
  input  logic [2:0] g_i,
  input  logic [2:0] p_i,
  input  logic       ci_i,
  output logic [3:0] c_o
);
  assign c_o[0] = ci_i;
  assign c_o[1] = g_i[0] | (p_i[0] & ci_i);
  assign c_o[2] = g_i[1] | (p_i[1] & g_i[0]) | (p_i[1] & p_i[0] & ci_i);
  assign c_o[3] = g_i[2] | (p_i[2] & g_i[1]) | (p_i[2] & p_i[1] & g_i[0])
                | (p_i[2] & p_i[1] & p_i[0] & ci_i);
endmodule

// File: rtl/hcla_la_tree.sv
// Radix-4 lookahead tree: group g/p upward, group carries downward.
module hcla_la_tree #(
  parameter int unsigned WIDTH = 256
) (
  input  logic [WIDTH-1:0]   g_i,
  input  logic [WIDTH-1:0]   p_i,
  input  logic               ci_i,
  output logic [WIDTH/4-1:0] gc_o,
  output logic               co_o
);
  localparam int unsigned LVL = $clog2(WIDTH) / 2;

  for (genvar l = 1; l <= LVL; l++) begin : lv
    localparam int unsigned NN = WIDTH >> (2 * l);
    logic [NN-1:0] g, p, c;

    for (genvar j = 0; j < NN; j++) begin : nd
      if (l == 1) begin : lf
        hcla_gp4 u_gp (
          .g_i(g_i[4*j +: 4]), .p_i(p_i[4*j +: 4]),
          .g_o(g[j]), .p_o(p[j])
        );
      end else begin : up
        hcla_gp4 u_gp (
          .g_i(lv[l-1].g[4*j +: 4]), .p_i(lv[l-1].p[4*j +: 4]),
          .g_o(g[j]), .p_o(p[j])
        );
      end
    end

    if (l == LVL) begin : rt
      assign c[0] = ci_i;
    end else begin : dn
      for (genvar j = 0; j < NN / 4; j++) begin : pr
        logic [3:0] c4;
        logic       unused_gp3;
        hcla_carry4 u_c4 (
          .g_i(g[4*j +: 3]), .p_i(p[4*j +: 3]),
          .ci_i(lv[l+1].c[j]), .c_o(c4)
        );
        assign c[4*j +: 4] = c4;
        assign unused_gp3  = g[4*j+3] ^ p[4*j+3];
      end
    end
  end

  assign gc_o = lv[1].c;
  assign co_o = lv[LVL].g[0] | (lv[LVL].p[0] & ci_i);
endmodule

// File: rtl/hcla_cond_group.sv
// Conditional-sum group: candidates for carry-in 0 and 1, picked by ci_i.
module hcla_cond_group
  import hcla_pkg::*;
#(
  parameter int unsigned W    = 4,
  parameter sel_mode_e   MODE = SEL_SUM_CARRY
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);
  localparam int unsigned ML = $clog2(W);

  if (MODE == SEL_SUM_CARRY) begin : sm
    for (genvar m = 0; m <= ML; m++) begin : lv
      localparam int unsigned NB = W >> m;
      logic [W-1:0]  s0, s1;
      logic [NB-1:0] k0, k1;
      if (m == 0) begin : init
        assign s0 = p_i;
        assign s1 = ~p_i;
        assign k0 = g_i;
        assign k1 = g_i | p_i;
      end else begin : mrg
        localparam int unsigned H = 1 << (m - 1);
        for (genvar b = 0; b < NB; b++) begin : blk
          assign s0[b*2*H +: H] = lv[m-1].s0[b*2*H +: H];
          assign s1[b*2*H +: H] = lv[m-1].s1[b*2*H +: H];
          for (genvar i = 0; i < H; i++) begin : hb
            hcla_mux2 u_s0 (
              .sel_i(lv[m-1].k0[2*b]), .d0_i(lv[m-1].s0[b*2*H+H+i]),
              .d1_i(lv[m-1].s1[b*2*H+H+i]), .y_o(s0[b*2*H+H+i])
            );
            hcla_mux2 u_s1 (
              .sel_i(lv[m-1].k1[2*b]), .d0_i(lv[m-1].s0[b*2*H+H+i]),
              .d1_i(lv[m-1].s1[b*2*H+H+i]), .y_o(s1[b*2*H+H+i])
            );
          end
          hcla_mux2 u_k0 (
            .sel_i(lv[m-1].k0[2*b]), .d0_i(lv[m-1].k0[2*b+1]),
            .d1_i(lv[m-1].k1[2*b+1]), .y_o(k0[b])
          );
          hcla_mux2 u_k1 (
            .sel_i(lv[m-1].k1[2*b]), .d0_i(lv[m-1].k0[2*b+1]),
            .d1_i(lv[m-1].k1[2*b+1]), .y_o(k1[b])
          );
        end
      end
    end

    for (genvar i = 0; i < W; i++) begin : fs
      hcla_mux2 u_fs (
        .sel_i(ci_i), .d0_i(lv[ML].s0[i]), .d1_i(lv[ML].s1[i]), .y_o(sum_o[i])
      );
    end
    hcla_mux2 u_fc (
      .sel_i(ci_i), .d0_i(lv[ML].k0[0]), .d1_i(lv[ML].k1[0]), .y_o(co_o)
    );

  end else begin : cm
    for (genvar m = 0; m <= ML; m++) begin : lv
      logic [W-1:0] k0, k1;
      if (m == 0) begin : init
        assign k0 = g_i;
        assign k1 = g_i | p_i;
      end else begin : mrg
        for (genvar i = 0; i < W; i++) begin : bt
          if (((i >> (m - 1)) & 1) == 1) begin : hi
            localparam int unsigned LE = ((i >> (m - 1)) << (m - 1)) - 1;
            hcla_mux2 u_k0 (
              .sel_i(lv[m-1].k0[LE]), .d0_i(lv[m-1].k0[i]),
              .d1_i(lv[m-1].k1[i]), .y_o(k0[i])
            );
            hcla_mux2 u_k1 (
              .sel_i(lv[m-1].k1[LE]), .d0_i(lv[m-1].k0[i]),
              .d1_i(lv[m-1].k1[i]), .y_o(k1[i])
            );
          end else begin : lo
            assign k0[i] = lv[m-1].k0[i];
            assign k1[i] = lv[m-1].k1[i];
          end
        end
      end
    end

    logic [W-1:0] cb;
    assign cb[0] = ci_i;
    for (genvar i = 1; i < W; i++) begin : fc
      hcla_mux2 u_cb (
        .sel_i(ci_i), .d0_i(lv[ML].k0[i-1]), .d1_i(lv[ML].k1[i-1]), .y_o(cb[i])
      );
    end
    assign sum_o = p_i ^ cb;
    hcla_mux2 u_co (
      .sel_i(ci_i), .d0_i(lv[ML].k0[W-1]), .d1_i(lv[ML].k1[W-1]), .y_o(co_o)
    );
  end
endmodule

// File: rtl/hcla_adder.sv
module hcla_adder
  import hcla_pkg::*;
#(
  parameter int unsigned WIDTH = 256,
  parameter sel_mode_e   MODE  = SEL_SUM_CARRY
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned NG = WIDTH / GRP_W;

  logic [WIDTH-1:0] bit_g, bit_p;
  logic [NG-1:0]    grp_ci, grp_co;
  logic             tree_co;
  logic             unused_grp_co;

  for (genvar i = 0; i < WIDTH; i++) begin : bgp
    assign bit_g[i] = a_i[i] & b_i[i];
    assign bit_p[i] = a_i[i] ^ b_i[i];
  end

  hcla_la_tree #(.WIDTH(WIDTH)) u_tree (
    .g_i (bit_g),
    .p_i (bit_p),
    .ci_i(cin_i),
    .gc_o(grp_ci),
    .co_o(tree_co)
  );

  for (genvar j = 0; j < NG; j++) begin : grp
    hcla_cond_group #(.W(GRP_W), .MODE(MODE)) u_grp (
      .g_i  (bit_g[GRP_W*j +: GRP_W]),
      .p_i  (bit_p[GRP_W*j +: GRP_W]),
      .ci_i (grp_ci[j]),
      .sum_o(sum_o[GRP_W*j +: GRP_W]),
      .co_o (grp_co[j])
    );
  end

  // carry-out from the tree root; group carry-outs are cross-check only
  assign cout_o        = tree_co;
  assign unused_grp_co = ^grp_co;
endmodule

// File: rtl/hcla_adder_chk.sv
module hcla_adder_chk
  import hcla_pkg::*;
#(
  parameter int unsigned WIDTH = 256,
  parameter sel_mode_e   MODE  = SEL_SUM_CARRY
) (
  input logic [WIDTH-1:0]       a_i,
  input logic [WIDTH-1:0]       b_i,
  input logic                   cin_i,
  input logic [WIDTH-1:0]       sum_i,
  input logic                   cout_i,
  input logic [WIDTH/GRP_W-1:0] grp_ci_i,
  input logic [WIDTH/GRP_W-1:0] grp_co_i
);
  localparam int unsigned NG = WIDTH / GRP_W;
  localparam logic [WIDTH-1:0] P01 = {(WIDTH/2){2'b01}};

  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  if (MODE == SEL_SUM_CARRY) begin : g_sc
    always_comb
      p_sum_ref_r1: assert ({cout_i, sum_i} == ref_sum)
        else $error("sum-and-carry result mismatch");
  end else begin : g_co
    always_comb
      p_sum_ref_r2: assert ({cout_i, sum_i} == ref_sum)
        else $error("carry-only result mismatch");
  end

  always_comb begin
    if ((&a_i) && (b_i == '0) && cin_i)
      p_all_ones_r3: assert (sum_i == '0 && cout_i) else $error("all-ones plus one");
    if (a_i == '0 && b_i == '0)
      p_zero_ops_r4: assert (sum_i == {{(WIDTH-1){1'b0}}, cin_i} && !cout_i)
        else $error("zero operands");
    if ((a_i ^ b_i) == '1)
      p_full_prop_r5: assert (sum_i == {WIDTH{~cin_i}} && cout_i == cin_i)
        else $error("full propagate");
    if (a_i == P01 && b_i == P01 && !cin_i)
      p_alt_chain_r6: assert (sum_i == ~P01 && !cout_i) else $error("alternating pattern");
  end

  always_comb begin
    p_grp_base_r7: assert (grp_ci_i[0] == cin_i) else $error("group 0 carry-in");
    p_grp_top_r7: assert (grp_co_i[NG-1] == cout_i) else $error("top group carry-out");
    for (int j = 0; j < NG - 1; j++)
      p_grp_link_r7: assert (grp_co_i[j] == grp_ci_i[j+1])
        else $error("group %0d carry link", j);
  end
endmodule

bind hcla_adder hcla_adder_chk #(.WIDTH(WIDTH), .MODE(MODE)) i_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_i   (sum_o),
  .cout_i  (cout_o),
  .grp_ci_i(grp_ci),
  .grp_co_i(grp_co)
);

// File: tb/test_hcla_adder.sv
module test_hcla_adder;
  import hcla_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int n_chk = 0;
  int n_err = 0;

  logic [255:0] a256 = '0, b256 = '0;
  logic         ci256 = 1'b0;
  logic [255:0] s_sc, s_co;
  logic         c_sc, c_co;

  logic [15:0]  a16 = '0, b16 = '0;
  logic         ci16 = 1'b0;
  logic [15:0]  s16_sc, s16_co;
  logic         c16_sc, c16_co;

  hcla_adder #(.WIDTH(256), .MODE(SEL_SUM_CARRY)) i_hcla_adder (
    .a_i(a256), .b_i(b256), .cin_i(ci256), .sum_o(s_sc), .cout_o(c_sc));
  hcla_adder #(.WIDTH(256), .MODE(SEL_CARRY_ONLY)) i_hcla_adder_co (
    .a_i(a256), .b_i(b256), .cin_i(ci256), .sum_o(s_co), .cout_o(c_co));
  hcla_adder #(.WIDTH(16), .MODE(SEL_SUM_CARRY)) i_hcla_adder_s16 (
    .a_i(a16), .b_i(b16), .cin_i(ci16), .sum_o(s16_sc), .cout_o(c16_sc));
  hcla_adder #(.WIDTH(16), .MODE(SEL_CARRY_ONLY)) i_hcla_adder_c16 (
    .a_i(a16), .b_i(b16), .cin_i(ci16), .sum_o(s16_co), .cout_o(c16_co));

  localparam logic [255:0] P01 = {128{2'b01}};
  localparam logic [255:0] P10 = ~P01;

  task automatic cmp(input string req, input string tag,
                     input logic [256:0] got, input logic [256:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s got %h exp %h", req, tag, got, exp);
    end
  endtask

  task automatic chk256(input string req_s, input string req_c,
                        input logic [255:0] a, input logic [255:0] b, input logic cin);
    logic [256:0] exp;
    a256 = a; b256 = b; ci256 = cin;
    exp = {1'b0, a} + {1'b0, b} + {256'd0, cin};
    @(negedge clk);
    cmp(req_s, "w256 sum-sel", {c_sc, s_sc}, exp);
    cmp(req_c, "w256 carry-sel", {c_co, s_co}, exp);
  endtask

  task automatic chk16(input string req_s, input string req_c,
                       input logic [15:0] a, input logic [15:0] b, input logic cin);
    logic [16:0] exp;
    a16 = a; b16 = b; ci16 = cin;
    exp = {1'b0, a} + {1'b0, b} + {16'd0, cin};
    @(negedge clk);
    cmp(req_s, "w16 sum-sel", {240'd0, c16_sc, s16_sc}, {240'd0, exp});
    cmp(req_c, "w16 carry-sel", {240'd0, c16_co, s16_co}, {240'd0, exp});
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[32*k +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    // reset: zero inputs must give zero outputs (R4)
    repeat (2) @(negedge clk);
    cmp("R4", "reset w256 sum-sel", {c_sc, s_sc}, '0);
    cmp("R4", "reset w256 carry-sel", {c_co, s_co}, '0);
    cmp("R4", "reset w16", {240'd0, c16_sc, s16_sc}, '0);
    rst_ni = 1'b1;

    // R3 all-ones plus one, both ways
    chk256("R3", "R3", '1, '0, 1'b1);
    chk256("R3", "R3", '1, 256'd1, 1'b0);
    chk16("R3", "R3", 16'hFFFF, 16'h0000, 1'b1);
    chk16("R3", "R3", 16'hFFFF, 16'h0001, 1'b0);
    cmp("R3", "explicit all-ones", {c_sc, s_sc}, {1'b0, 256'd0} | {1'b1, 256'd0});

    // R4 zero operands with carry-in
    chk256("R4", "R4", '0, '0, 1'b1);
    chk256("R4", "R4", '0, '0, 1'b0);
    chk16("R4", "R4", 16'h0, 16'h0, 1'b1);

    // R5 full propagate
    for (int k = 0; k < 8; k++) begin
      logic [255:0] r;
      r = rnd256();
      chk256("R5", "R5", r, ~r, k[0]);
    end
    chk256("R5", "R5", '0, '1, 1'b1);
    chk16("R5", "R5", 16'h1234, 16'hEDCB, 1'b1);

    // R6 alternating patterns
    chk256("R6", "R6", P01, P01, 1'b0);
    chk256("R6", "R6", P10, P10, 1'b0);
    chk256("R6", "R6", P01, P10, 1'b0);
    chk256("R6", "R6", P01, P10, 1'b1);
    chk256("R6", "R6", P10, P01, 1'b1);
    chk16("R6", "R6", 16'h5555, 16'hAAAA, 1'b1);

    // R7 carry made in group j lands in bit 4j+4
    for (int j = 0; j < 64; j++) begin
      chk256("R7", "R7", 256'hF << (4 * j), 256'd1 << (4 * j), 1'b0);
      chk256("R7", "R7", 256'hE << (4 * j), 256'd1 << (4 * j), 1'b1);
    end
    for (int j = 0; j < 4; j++)
      chk16("R7", "R7", 16'hF << (4 * j), 16'd1 << (4 * j), 1'b0);

    // R1/R2 random full-width operands
    for (int k = 0; k < 600; k++)
      chk256("R1", "R2", rnd256(), rnd256(), 1'($urandom));
    for (int k = 0; k < 64; k++) begin
      logic [255:0] r;
      r = rnd256();
      chk256("R1", "R2", r, ~r ^ (256'd1 << k), k[1]);
    end

    // R1/R2 sweep of every 16-bit first operand
    for (int v = 0; v < 65536; v++)
      chk16("R1", "R2", 16'(v), 16'((v * 40503) ^ (v >> 3)), v[0] ^ v[9]);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule